// File: doc/BRIEF.md
# Paged Program Counter with Return Stack

This block sequences instruction fetch for a small 8-bit controller whose program memory holds 1024 words of 14 bits. It keeps a 10-bit program counter and a two-level hardware return stack. Each enabled cycle, it takes a decoded control class from the instruction decoder and picks the next fetch address. The class selects between the sequential successor and several other targets. The skip class jumps over one word. The write-PC class takes its target from the ALU result. The short-jump and short-call classes use a narrow immediate extended by the status page bit. The long-jump and long-call classes use a full-width immediate. The return class restores an address from the stack.

The upper address bits come from different sources depending on the class. A short jump carries nine address bits, so only the top bit comes from the page flag. A short call and a PC write carry eight bits, so bit 8 is forced to zero and bit 9 comes from the page flag. The page flag selects the lower half (0x000–0x1FF) when 0 and the upper half (0x200–0x3FF) when 1. Call classes save the address after the call. A push onto a full stack discards the oldest saved address. A return with nothing saved yields the address that was restored most recently.

Reset is asserted asynchronously by an active-low input. It is released inside the block through a two-stage synchronizer, so the block ignores `step_en` for two clock edges after `rst_n` rises.

Top module: `pcseq_top`

## Requirements
- R1: While reset is asserted, `fetch_addr` is 0x3FF and `pc_low` is 0xFF, and every stack entry is cleared to 0x000.
- R2: Class 0 (sequential) with `step_en` high loads PC+1 at the next rising edge. The count wraps from 0x3FF to 0x000.
- R3: Class 1 (skip) with `step_en` high loads PC+2, modulo 1024. For example, 0x3FE goes to 0x000.
- R4: With `step_en` low, the PC and the stack keep their values, whatever the class and data inputs are.
- R5: Class 5 (long jump) and class 6 (long call) load all ten bits of `imm`.
- R6: Class 3 (short jump) loads {`page_sel`, `imm[8:0]`}. `imm[9]` is ignored.
- R7: Class 4 (short call) loads {`page_sel`, 1'b0, `imm[7:0]`}. `imm[9:8]` is ignored.
- R8: Class 2 (write PC) loads {`page_sel`, 1'b0, `alu_res[7:0]`}.
- R9: Classes 4 and 6 push PC+1 (the address after the call, modulo 1024). Class 7 (return) loads the most recently pushed address and removes it from the stack.
- R10: A push while both levels are occupied discards the oldest entry and keeps the two newest.
- R11: A return while the stack is empty reloads the address restored by the previous return. Right after reset, it loads 0x000.
- R12: `pc_low` always equals bits 7..0 of `fetch_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| step_en | input | 1 | Advances the PC and updates the stack this cycle |
| ctl_class | input | 3 | Decoded control class, encoded 0..7 as listed in the requirements |
| imm | input | 10 | Immediate address field from the instruction word |
| alu_res | input | 8 | ALU result used by the write-PC class |
| page_sel | input | 1 | Page select bit from the status register |
| fetch_addr | output | 10 | Current program counter, used as the fetch address |
| pc_low | output | 8 | Low byte of the PC as seen by a register read |

## Verification
Every result is registered. A class presented with `step_en` high shows up on `fetch_addr` and `pc_low` right after the next rising edge. A stack effect shows up when a later return is stepped, one edge after that return. The bench drives inputs at falling edges and samples at the following falling edge, one full edge after each update. After `rst_n` rises, it waits three falling edges so that the two-stage synchronizer has let go before it steps. The reset value is checked while `rst_n` is still low.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
  typedef enum logic [2:0] {
    CLS_SEQ   = 3'd0,
    CLS_SKIP  = 3'd1,
    CLS_WRPC  = 3'd2,
    CLS_SJMP  = 3'd3,
    CLS_SCALL = 3'd4,
    CLS_LJMP  = 3'd5,
    CLS_LCALL = 3'd6,
    CLS_RET   = 3'd7
  } ctl_cls_e;
endpackage

// File: rtl/pcseq_rst_sync.sv
module pcseq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/pcseq_target.sv
module pcseq_target
  import pcseq_pkg::*;
#(
  parameter int PC_W   = 10,
  parameter int DATA_W = 8
) (
  input  ctl_cls_e          cls,
  input  logic [PC_W-1:0]   pc,
  input  logic [PC_W-1:0]   imm,
  input  logic [DATA_W-1:0] alu,
  input  logic              page,
  input  logic [PC_W-1:0]   pop_val,
  output logic [PC_W-1:0]   nxt,
  output logic [PC_W-1:0]   ret_addr,
  output logic              push_req,
  output logic              pop_req
);
  localparam int ZPAD = PC_W - 1 - DATA_W;

  logic [PC_W-1:0] short_tgt;
  logic [PC_W-1:0] byte_alu;

  assign ret_addr  = pc + PC_W'(1);
  assign short_tgt = {page, {ZPAD{1'b0}}, imm[DATA_W-1:0]};
  assign byte_alu  = {page, {ZPAD{1'b0}}, alu};

  always_comb begin
    nxt      = ret_addr;
    push_req = 1'b0;
    pop_req  = 1'b0;
    unique case (cls)
      CLS_SEQ:   nxt = ret_addr;
      CLS_SKIP:  nxt = pc + PC_W'(2);
      CLS_WRPC:  nxt = byte_alu;
      CLS_SJMP:  nxt = {page, imm[PC_W-2:0]};
      CLS_SCALL: begin nxt = short_tgt; push_req = 1'b1; end
      CLS_LJMP:  nxt = imm;
      CLS_LCALL: begin nxt = imm; push_req = 1'b1; end
      CLS_RET:   begin nxt = pop_val; pop_req = 1'b1; end
      default:   nxt = ret_addr;
    endcase
  end
endmodule

// File: rtl/pcseq_stack.sv
module pcseq_stack #(
  parameter int PC_W  = 10,
  parameter int DEPTH = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            push,
  input  logic            pop,
  input  logic [PC_W-1:0] push_val,
  output logic [PC_W-1:0] top_val
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [PC_W-1:0]  ent_q [DEPTH];
  logic [PC_W-1:0]  ent_d [DEPTH];
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    for (int i = 0; i < DEPTH; i++) ent_d[i] = ent_q[i];
    if (push) begin
      ent_d[0] = push_val;
      for (int i = 1; i < DEPTH; i++) ent_d[i] = ent_q[i-1];
      if (int'(cnt_q) < DEPTH) cnt_d = cnt_q + CNT_W'(1);
    end else if (pop) begin
      for (int i = 0; i < DEPTH - 1; i++)
        if (int'(cnt_q) > i + 1) ent_d[i] = ent_q[i+1];
      if (cnt_q != '0) cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (en) cnt_q <= cnt_d;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  ent_q[g] <= '0;
      else if (en) ent_q[g] <= ent_d[g];
    end
  end

  assign top_val = ent_q[0];
endmodule

// File: rtl/pcseq_top.sv
module pcseq_top
  import pcseq_pkg::*;
#(
  parameter int PC_W      = 10,
  parameter int DATA_W    = 8,
  parameter int STK_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic [2:0]        ctl_class,
  input  logic [PC_W-1:0]   imm,
  input  logic [DATA_W-1:0] alu_res,
  input  logic              page_sel,
  output logic [PC_W-1:0]   fetch_addr,
  output logic [DATA_W-1:0] pc_low
);
  logic            rst_core_n;
  logic [PC_W-1:0] pc_q, pc_d;
  logic [PC_W-1:0] stk_top;
  logic [PC_W-1:0] ret_addr;
  logic            push_req, pop_req;
  ctl_cls_e        cls;

  assign cls = ctl_cls_e'(ctl_class);

  pcseq_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  pcseq_target #(.PC_W(PC_W), .DATA_W(DATA_W)) i_target (
    .cls      (cls),
    .pc       (pc_q),
    .imm      (imm),
    .alu      (alu_res),
    .page     (page_sel),
    .pop_val  (stk_top),
    .nxt      (pc_d),
    .ret_addr (ret_addr),
    .push_req (push_req),
    .pop_req  (pop_req)
  );

  pcseq_stack #(.PC_W(PC_W), .DEPTH(STK_DEPTH)) i_stack (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .en       (step_en),
    .push     (push_req),
    .pop      (pop_req),
    .push_val (ret_addr),
    .top_val  (stk_top)
  );

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)   pc_q <= '1;
    else if (step_en)  pc_q <= pc_d;
  end

  assign fetch_addr = pc_q;
  assign pc_low     = pc_q[DATA_W-1:0];
endmodule

// File: rtl/pcseq_chk.sv
module pcseq_chk #(
  parameter int PC_W = 10
) (
  input logic            clk,
  input logic            rst_core_n,
  input logic            step_en,
  input logic [2:0]      ctl_class,
  input logic [PC_W-1:0] imm,
  input logic            page_sel,
  input logic [PC_W-1:0] stk_top,
  input logic [PC_W-1:0] fetch_addr
);
  AST_SEQ_INC: assert property (@(posedge clk) disable iff (!rst_core_n)
    (step_en && ctl_class == 3'd0) |=> fetch_addr == PC_W'($past(fetch_addr) + PC_W'(1))); // R2

  AST_SKIP_INC: assert property (@(posedge clk) disable iff (!rst_core_n)
    (step_en && ctl_class == 3'd1) |=> fetch_addr == PC_W'($past(fetch_addr) + PC_W'(2))); // R3

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_core_n)
    !step_en |=> $stable(fetch_addr)); // R4

  AST_LONG_LOAD: assert property (@(posedge clk) disable iff (!rst_core_n)
    (step_en && (ctl_class == 3'd5 || ctl_class == 3'd6)) |=> fetch_addr == $past(imm)); // R5

  AST_SHORT_JUMP: assert property (@(posedge clk) disable iff (!rst_core_n)
    (step_en && ctl_class == 3'd3) |=> fetch_addr == {$past(page_sel), $past(imm[PC_W-2:0])}); // R6

  AST_RET_POP: assert property (@(posedge clk) disable iff (!rst_core_n)
    (step_en && ctl_class == 3'd7) |=> fetch_addr == $past(stk_top)); // R9
endmodule

bind pcseq_top pcseq_chk #(.PC_W(PC_W)) i_pcseq_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .step_en    (step_en),
  .ctl_class  (ctl_class),
  .imm        (imm),
  .page_sel   (page_sel),
  .stk_top    (stk_top),
  .fetch_addr (fetch_addr)
);

// File: tb/test_pcseq_top.sv
module test_pcseq_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       step_en;
  logic [2:0] ctl_class;
  logic [9:0] imm;
  logic [7:0] alu_res;
  logic       page_sel;
  logic [9:0] fetch_addr;
  logic [7:0] pc_low;

  int n_chk = 0;
  int n_bad = 0;

  logic [9:0] m_pc;
  logic [9:0] m_stk [2];
  int         m_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcseq_top i_pcseq_top (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .ctl_class(ctl_class),
    .imm(imm), .alu_res(alu_res), .page_sel(page_sel),
    .fetch_addr(fetch_addr), .pc_low(pc_low)
  );

  task automatic check(string req, logic [9:0] act, logic [9:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] exp_next(logic [2:0] c, logic [9:0] pc,
                                          logic [9:0] im, logic [7:0] al,
                                          logic pg, logic [9:0] top);
    case (c)
      3'd0: return pc + 10'd1;
      3'd1: return pc + 10'd2;
      3'd2: return {pg, 1'b0, al};
      3'd3: return {pg, im[8:0]};
      3'd4: return {pg, 1'b0, im[7:0]};
      3'd5, 3'd6: return im;
      default: return top;
    endcase
  endfunction

  task automatic model_step(logic [2:0] c, logic [9:0] im, logic [7:0] al, logic pg);
    logic [9:0] nx;
    nx = exp_next(c, m_pc, im, al, pg, m_stk[0]);
    if (c == 3'd4 || c == 3'd6) begin
      m_stk[1] = m_stk[0];
      m_stk[0] = m_pc + 10'd1;
      if (m_cnt < 2) m_cnt++;
    end else if (c == 3'd7) begin
      if (m_cnt == 2) m_stk[0] = m_stk[1];
      if (m_cnt > 0) m_cnt--;
    end
    m_pc = nx;
  endtask

  task automatic do_step(logic en, logic [2:0] c, logic [9:0] im,
                         logic [7:0] al, logic pg, string req);
    step_en = en; ctl_class = c; imm = im; alu_res = al; page_sel = pg;
    @(posedge clk);
    if (en) model_step(c, im, al, pg);
    @(negedge clk);
    check(req, fetch_addr, m_pc);
    check("R12", {2'b00, pc_low}, {2'b00, m_pc[7:0]});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    rst_n = 1'b0; step_en = 1'b0; ctl_class = 3'd0; imm = '0; alu_res = '0; page_sel = 1'b0;
    m_pc = 10'h3FF; m_stk[0] = '0; m_stk[1] = '0; m_cnt = 0;
    repeat (3) @(negedge clk);
    check("R1", fetch_addr, 10'h3FF);
    check("R1", {2'b00, pc_low}, 10'h0FF);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R4", fetch_addr, 10'h3FF);

    do_step(1, 3'd0, 10'h155, 8'h00, 1'b0, "R2");   // 0x3FF wraps to 0x000
    do_step(1, 3'd7, 10'h000, 8'h00, 1'b1, "R11");  // empty pop after reset gives 0x000
    do_step(1, 3'd5, 10'h3FE, 8'h00, 1'b0, "R5");
    do_step(1, 3'd1, 10'h000, 8'h00, 1'b0, "R3");   // 0x3FE skips to 0x000
    do_step(1, 3'd3, 10'h3AB, 8'h00, 1'b1, "R6");   // imm[9] ignored -> 0x3AB
    do_step(1, 3'd3, 10'h3AB, 8'h00, 1'b0, "R6");   // page 0 -> 0x1AB
    do_step(1, 3'd4, 10'h3C5, 8'h00, 1'b0, "R7");   // -> 0x0C5, push 0x1AC
    do_step(1, 3'd6, 10'h2F0, 8'h00, 1'b0, "R5");   // push 0x0C6, stack full
    do_step(1, 3'd4, 10'h012, 8'h00, 1'b1, "R7");   // -> 0x212, push 0x2F1, drop 0x1AC
    do_step(1, 3'd7, 10'h000, 8'h00, 1'b0, "R9");   // -> 0x2F1
    do_step(1, 3'd7, 10'h000, 8'h00, 1'b0, "R10");  // -> 0x0C6, oldest was dropped
    do_step(1, 3'd7, 10'h000, 8'h00, 1'b0, "R11");  // empty -> 0x0C6 again
    do_step(1, 3'd2, 10'h3FF, 8'h5A, 1'b1, "R8");   // -> 0x25A
    do_step(1, 3'd2, 10'h000, 8'hFF, 1'b0, "R8");   // -> 0x0FF
    do_step(0, 3'd5, 10'h123, 8'h77, 1'b1, "R4");   // no change
    do_step(0, 3'd6, 10'h321, 8'h00, 1'b0, "R4");   // no push either
    do_step(1, 3'd7, 10'h000, 8'h00, 1'b0, "R4");   // stack still returns 0x0C6

    for (int k = 0; k < 600; k++) begin
      logic [2:0] c;
      c = 3'($urandom_range(0, 7));
      do_step(($urandom_range(0, 7) != 0), c, 10'($urandom()), 8'($urandom()),
              1'($urandom()), "R9 random");
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule